// File: doc/BRIEF.md
# Serial Flash-Bus Frame Master

This block is the host end of a four-wire serial link. At the far end of the link sits a shift-register latch that drives the pins of a parallel 8-bit flash device. A requester hands the block one access at a time. The access carries a data byte, the three active-low strobes (write enable, output enable, chip enable) and a 16-bit address. The block turns that access into a fixed 30-bit serial frame on a divided serial clock. It then raises a load line for one full clock pulse, so the remote latch copies the frame onto the flash pins.

When the strobes describe a read (write enable high, output and chip enable low), the block keeps the load line high for a second clock pulse. That second pulse makes the remote side capture the flash data bus. The block then clocks the eight captured bits back in, most significant bit first. It presents the byte with a single-cycle valid pulse. The serial clock comes from the system clock through a parameterised divider with equal low and high phases. Outputs change only at the start of a low phase, so every bit has at least one full low phase of setup before its rising edge.

Top module: `sflash_frame_master`

## Requirements
- R1: The frame has 30 bits, sent one per serial clock pulse in this order: the data byte from bit 7 to bit 0, then the write-enable, output-enable and chip-enable bits, then three 0 bits, then the address from bit 15 to bit 0.
- R2: Each serial clock pulse is HALF_CYCLES system cycles low followed by HALF_CYCLES cycles high. The serial data and load lines change only on the cycle the clock returns low, so they hold steady from the start of the low phase through the end of the high phase.
- R3: Right after the 30th bit, one extra clock pulse is issued with the load line high and the serial data line 0. The load line is low during every frame bit.
- R4: A request whose strobes are write-enable 1, output-enable 0, chip-enable 0 is a read. For a read, the load line stays high for a second pulse right after the first. Then 8 return pulses follow with the load line low and the serial data line 0.
- R5: During each of the 8 return pulses, the return line is sampled on the system cycle just before the rising clock edge, and the bits are assembled most significant first. The byte appears on rd_data with rd_valid high for exactly one cycle, the same cycle busy falls.
- R6: While idle, a high req is accepted at the next clock edge. ack is then high for one cycle and busy is high from that cycle on. A req raised while busy is ignored, and the frame in flight continues unchanged.
- R7: A request that is not a read ends after the first load pulse: busy falls 31 pulses (62*HALF_CYCLES cycles) after ack, and rd_valid stays low.
- R8: After reset, sclk, sload, sdout, busy, ack and rd_valid are all 0.
- R9: While busy is low, sclk, sload and sdout stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until ack |
| req_data | input | 8 | Data byte for the flash data pins |
| req_we_n | input | 1 | Write-enable level for the frame (1 = inactive) |
| req_oe_n | input | 1 | Output-enable level for the frame (1 = inactive) |
| req_ce_n | input | 1 | Chip-enable level for the frame (1 = inactive) |
| req_addr | input | 16 | Flash address |
| ack | output | 1 | One-cycle pulse: request accepted |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds the byte read back |
| rd_data | output | 8 | Byte read back from the flash data bus |
| sclk | output | 1 | Serial clock to the remote latch |
| sload | output | 1 | Load line to the remote latch |
| sdout | output | 1 | Serial data to the remote latch |
| sdin | input | 1 | Serial return data from the remote latch |

## Verification
The bench pairs the block with a behavioural remote latch and flash array, and predicts every output of every cycle from the request alone. A swap of the strobe bits, the padding or the address bit order would send writes to the wrong location, and the bench would then see wrong bytes on later reads. A design that samples the return line after the rising edge instead of before it would return each byte shifted by one bit. A design that dropped the second load pulse would return stale bus data. Reads of never-written cells and all-zero and all-one data bytes are also covered. A req held high through a transfer is checked to cause no second ack and no change to the frame in flight. A design that re-latched its inputs then would corrupt the frame visibly.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SHIFT = 3'd1,
        ST_LOAD  = 3'd2,
        ST_CAPT  = 3'd3,
        ST_RECV  = 3'd4
    } sfm_state_e;

    localparam int unsigned STROBE_W = 3;

endpackage

// File: rtl/sfm_frame_pack.sv
module sfm_frame_pack #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned PAD_W  = 3,
    localparam int unsigned FRAME_W = DATA_W + sfm_pkg::STROBE_W + PAD_W + ADDR_W
) (
    input  logic [DATA_W-1:0]  data,
    input  logic               we_n,
    input  logic               oe_n,
    input  logic               ce_n,
    input  logic [ADDR_W-1:0]  addr,
    output logic [FRAME_W-1:0] frame,
    output logic               is_read
);

    // Leftmost bit leaves the master first.
    assign frame   = {data, we_n, oe_n, ce_n, {PAD_W{1'b0}}, addr};
    assign is_read = we_n & ~oe_n & ~ce_n;

endmodule

// File: rtl/sfm_phase_timer.sv
module sfm_phase_timer #(
    parameter int unsigned HALF_CYCLES = 3,
    localparam int unsigned CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic rise_stb,
    output logic fall_stb,
    output logic sclk
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hi;
    } tmr_t;

    tmr_t q, d;
    logic last;

    assign last     = (q.cnt == CNT_W'(HALF_CYCLES - 1));
    assign rise_stb = run & ~q.hi & last;
    assign fall_stb = run &  q.hi & last;
    assign sclk     = q.hi;

    always_comb begin
        d = q;
        if (!run) begin
            d.cnt = '0;
            d.hi  = 1'b0;
        end else if (last) begin
            d.cnt = '0;
            d.hi  = ~q.hi;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/sflash_frame_master.sv
module sflash_frame_master #(
    parameter int unsigned HALF_CYCLES = 3,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned PAD_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_we_n,
    input  logic              req_oe_n,
    input  logic              req_ce_n,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              ack,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sclk,
    output logic              sload,
    output logic              sdout,
    input  logic              sdin
);
    import sfm_pkg::*;

    localparam int unsigned FRAME_W = DATA_W + STROBE_W + PAD_W + ADDR_W;
    localparam int unsigned BIT_W   = $clog2(FRAME_W);

    typedef struct packed {
        sfm_state_e         st;
        logic [FRAME_W-1:0] frame;
        logic [BIT_W-1:0]   bit_cnt;
        logic               rd;
        logic [DATA_W-1:0]  rx;
        logic [DATA_W-1:0]  rd_data;
        logic               sload;
        logic               sdout;
        logic               busy;
        logic               ack;
        logic               rd_valid;
    } fm_t;

    fm_t q, d;

    logic [FRAME_W-1:0] frame_in;
    logic               is_read_in;
    logic               rise_stb;
    logic               fall_stb;
    logic               sclk_w;

    sfm_frame_pack #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .PAD_W  (PAD_W)
    ) pack_i (
        .data    (req_data),
        .we_n    (req_we_n),
        .oe_n    (req_oe_n),
        .ce_n    (req_ce_n),
        .addr    (req_addr),
        .frame   (frame_in),
        .is_read (is_read_in)
    );

    sfm_phase_timer #(
        .HALF_CYCLES (HALF_CYCLES)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (q.busy),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .sclk     (sclk_w)
    );

    always_comb begin
        d          = q;
        d.ack      = 1'b0;
        d.rd_valid = 1'b0;

        if (q.st == ST_IDLE) begin
            if (req) begin
                d.st      = ST_SHIFT;
                d.frame   = frame_in;
                d.rd      = is_read_in;
                d.bit_cnt = '0;
                d.rx      = '0;
                d.sdout   = frame_in[FRAME_W-1];
                d.sload   = 1'b0;
                d.busy    = 1'b1;
                d.ack     = 1'b1;
            end
        end else begin
            // Return bit is taken just before the remote register advances.
            if (rise_stb && q.st == ST_RECV) begin
                d.rx = {q.rx[DATA_W-2:0], sdin};
            end

            if (fall_stb) begin
                unique case (q.st)
                    ST_SHIFT: begin
                        if (q.bit_cnt == BIT_W'(FRAME_W - 1)) begin
                            d.st    = ST_LOAD;
                            d.sload = 1'b1;
                            d.sdout = 1'b0;
                        end else begin
                            d.bit_cnt = q.bit_cnt + 1'b1;
                            d.frame   = {q.frame[FRAME_W-2:0], 1'b0};
                            d.sdout   = q.frame[FRAME_W-2];
                        end
                    end
                    ST_LOAD: begin
                        if (q.rd) begin
                            d.st = ST_CAPT;
                        end else begin
                            d.st    = ST_IDLE;
                            d.sload = 1'b0;
                            d.busy  = 1'b0;
                        end
                    end
                    ST_CAPT: begin
                        d.st      = ST_RECV;
                        d.sload   = 1'b0;
                        d.bit_cnt = '0;
                    end
                    ST_RECV: begin
                        if (q.bit_cnt == BIT_W'(DATA_W - 1)) begin
                            d.st       = ST_IDLE;
                            d.busy     = 1'b0;
                            d.rd_valid = 1'b1;
                            d.rd_data  = q.rx;
                        end else begin
                            d.bit_cnt = q.bit_cnt + 1'b1;
                        end
                    end
                    default: d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign ack      = q.ack;
    assign busy     = q.busy;
    assign rd_valid = q.rd_valid;
    assign rd_data  = q.rd_data;
    assign sclk     = sclk_w;
    assign sload    = q.sload;
    assign sdout    = q.sdout;

endmodule

// File: rtl/sflash_frame_master_checker.sv
module sflash_frame_master_checker (
    input logic clk,
    input logic rst_n,
    input logic ack,
    input logic busy,
    input logic rd_valid,
    input logic sclk,
    input logic sload,
    input logic sdout
);

    assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_ack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> busy);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !sload && !sdout));

    assert_setup_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sclk) |-> ($stable(sdout) && $stable(sload)));

    assert_load_no_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sload |-> !sdout);

    assert_rdvalid_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($fell(busy) && !sclk));

    assert_rdvalid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

bind sflash_frame_master sflash_frame_master_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .busy     (busy),
    .rd_valid (rd_valid),
    .sclk     (sclk),
    .sload    (sload),
    .sdout    (sdout)
);

// File: tb/sflash_frame_master_tb_top.sv
`timescale 1ns/1ps
module sflash_frame_master_tb_top;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [7:0]  req_data = '0;
    logic        req_we_n = 1'b1;
    logic        req_oe_n = 1'b1;
    logic        req_ce_n = 1'b1;
    logic [15:0] req_addr = '0;
    logic        ack, busy, rd_valid, sclk, sload, sdout, sdin;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sflash_frame_master #(.HALF_CYCLES(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_data(req_data),
        .req_we_n(req_we_n), .req_oe_n(req_oe_n), .req_ce_n(req_ce_n),
        .req_addr(req_addr), .ack(ack), .busy(busy), .rd_valid(rd_valid),
        .rd_data(rd_data), .sclk(sclk), .sload(sload), .sdout(sdout), .sdin(sdin)
    );

    // Behavioural remote latch and flash array.
    logic [29:0] ser = '0;
    logic [29:0] lat = 30'h3FFFFFFF;
    logic [7:0]  ret = '0;
    logic [7:0]  fmem [int];
    logic [7:0]  exp_mem [int];

    function automatic logic [7:0] bus_val(input logic [29:0] l);
        int k = int'(l[15:0]);
        if (!l[19] && !l[20]) return fmem.exists(k) ? fmem[k] : 8'hFF;
        return 8'hFF;
    endfunction

    always @(posedge sclk) begin
        if (sload) begin
            lat <= ser;
            ret <= bus_val(lat);
            if (!ser[21] && !ser[19]) fmem[int'(ser[15:0])] = ser[29:22];
        end else begin
            ser <= {ser[28:0], sdout};
            ret <= {ret[6:0], 1'b0};
        end
    end
    assign sdin = ret[7];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One access, compared on every cycle against a behavioural model.
    task automatic txn(input logic [7:0] dat, input bit we, input bit oe, input bit ce,
                       input logic [15:0] adr, input bit nag);
        bit          is_rd = we && !oe && !ce;
        logic [29:0] fr = {dat, we, oe, ce, 3'b000, adr};
        int          nslot = is_rd ? 40 : 31;
        int          total = nslot * 2 * HALF;
        int          k = 0;
        logic [7:0]  exp_rd;
        int          key = int'(adr);
        exp_rd = exp_mem.exists(key) ? exp_mem[key] : 8'hFF;
        if (!we && !ce) exp_mem[key] = dat;

        req = 1'b1; req_data = dat; req_we_n = we; req_oe_n = oe; req_ce_n = ce; req_addr = adr;
        @(posedge clk); @(negedge clk);
        req = 1'b0;
        for (int s = 0; s < nslot; s++) begin
            string tag;
            bit    e_load, e_dout;
            if (s < 30)      begin tag = "R1"; e_load = 0; e_dout = fr[29 - s]; end
            else if (s == 30) begin tag = "R3"; e_load = 1; e_dout = 0; end
            else if (s == 31) begin tag = "R4"; e_load = 1; e_dout = 0; end
            else              begin tag = "R4"; e_load = 0; e_dout = 0; end
            for (int h = 0; h < 2; h++) begin
                for (int c = 0; c < HALF; c++) begin
                    logic [5:0] act, exp;
                    if (nag && k == 5) begin
                        req = 1'b1; req_data = ~dat; req_we_n = 1'b0; req_ce_n = 1'b0; req_addr = ~adr;
                    end
                    if (nag && k == total - 4) req = 1'b0;
                    act = {sclk, sload, sdout, busy, ack, rd_valid};
                    exp = {h[0], e_load, e_dout, 1'b1, (k == 0), 1'b0};
                    chk(act == exp, (k == 0) ? "R6" : (h == 0 ? tag : "R2"), 32'(act), 32'(exp));
                    k++;
                    @(negedge clk);
                end
            end
        end
        chk(!busy && !sclk && !sload && !sdout, is_rd ? "R5" : "R7",
            {28'd0, busy, sclk, sload, sdout}, 32'd0);
        chk(rd_valid == is_rd, is_rd ? "R5" : "R7", 32'(rd_valid), 32'(is_rd));
        if (is_rd) chk(rd_data == exp_rd, "R5", 32'(rd_data), 32'(exp_rd));
        @(negedge clk);
        chk(!rd_valid && !busy && !ack, "R9", {29'd0, rd_valid, busy, ack}, 32'd0);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_sim();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({sclk, sload, sdout, busy, ack, rd_valid} == 6'b0, "R8",
            32'({sclk, sload, sdout, busy, ack, rd_valid}), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({sclk, sload, sdout, busy} == 4'b0, "R9", 32'({sclk, sload, sdout, busy}), 32'd0);

        // Idle frame, then writes with varied patterns (R1, R3, R7).
        txn(8'h00, 1, 1, 1, 16'h0000, 0);
        txn(8'hA5, 0, 1, 0, 16'h1234, 0);
        txn(8'hFF, 0, 1, 0, 16'hFFFF, 0);
        txn(8'h00, 0, 1, 0, 16'h8001, 0);
        txn(8'h3C, 0, 1, 0, 16'h0000, 0);
        // Reads of written and unwritten cells (R4, R5).
        txn(8'h00, 1, 0, 0, 16'h1234, 0);
        txn(8'h00, 1, 0, 0, 16'hFFFF, 0);
        txn(8'hFF, 1, 0, 0, 16'h8001, 0);
        txn(8'h00, 1, 0, 0, 16'h0000, 0);
        txn(8'h00, 1, 0, 0, 16'h4242, 0);
        // Request held high while busy is ignored (R6).
        txn(8'h96, 0, 1, 0, 16'h2AAA, 1);
        txn(8'h00, 1, 0, 0, 16'h2AAA, 1);
        txn(8'h00, 1, 0, 0, 16'hD555, 0);
        // Strobes not forming a read: chip disabled (R7).
        txn(8'h00, 1, 0, 1, 16'h1234, 0);

        done = 1;
        finish_sim();
    end

endmodule